// File: doc/BRIEF.md
# Delay-Line Bin Calibration and Fine-Time Lookup

This block serves the interpolating part of a coarse/fine time-to-digital converter. It has two delay lines, one for the start event and one for the stop event. Each line delivers a sampled thermometer code. The block turns each code into a bin index by counting its ones.

After reset the block calibrates. Each asserted `cal_hit_i` cycle stands for one random, asynchronous calibration event. That event increments the histogram entry of its bin, separately on each line. When a fixed power-of-two number of events has been taken, the block converts each histogram into a cumulative table that points at bin centres. It writes one entry per cycle. After the last entry it raises `cal_done_o`.

In the measurement phase, the start and stop levels are each synchronised through two flops. The rising edge of the synchronised start flag does three things: it looks up fine time 1 from the start line's table, it clears the coarse cycle counter, and it starts that counter. The rising edge of the synchronised stop flag looks up fine time 2 from the stop line's table, freezes the coarse count and pulses `result_valid_o`.

Top module: `tdc_cal_engine`

## Requirements
- R1: After reset, `cal_done_o` and `result_valid_o` are 0 and the block is in calibration.
- R2: A bin index equals the number of 1 bits in the 255-bit thermometer code (bins 0..255), so an isolated zero inside the run of ones does not change the index.
- R3: Every accepted calibration event adds exactly one to the histogram entry of its bin on each line, including events that hit the same bin in consecutive cycles.
- R4: Calibration accepts exactly 2^CAL_LOG2 events (1024 by default, at most 2^14 so a 15-bit entry cannot wrap); `cal_hit_i` after that count has no effect on any table.
- R5: Table entry i (21 bits) equals the sum of the histogram counts of bins below i plus floor(count of bin i / 2); entries are written one per cycle, and `cal_done_o` rises only after all 256 have been written.
- R6: `start_i` and `stop_i` are asynchronous levels; each passes two flip-flops, and only the rising edge of the synchronised flag is an event.
- R7: On a stop event that closes a measurement, `result_valid_o` pulses for one cycle, and in that cycle `fine1_o` holds the start-line table entry of the start code present at the start event and `fine2_o` the stop-line entry of the stop code present at the stop event.
- R8: `coarse_o` is the number of clock edges from the synchronised start rise to the synchronised stop rise, modulo 64. If both rise in the same cycle, the result is 0.
- R9: Start and stop events before `cal_done_o` is 1 produce no result.
- R10: A stop event with no open measurement produces no result, and a second start event while a measurement is open restarts the coarse count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_hit_i | input | 1 | One calibration event this cycle |
| start_therm_i | input | 255 | Sampled thermometer code of the start delay line |
| stop_therm_i | input | 255 | Sampled thermometer code of the stop delay line |
| start_i | input | 1 | Asynchronous start level |
| stop_i | input | 1 | Asynchronous stop level |
| cal_done_o | output | 1 | Tables built, measurement enabled |
| result_valid_o | output | 1 | One-cycle pulse when a result is present |
| fine1_o | output | 21 | Accumulated count for the start event |
| fine2_o | output | 21 | Accumulated count for the stop event |
| coarse_o | output | 6 | Coarse clock-edge count |

## Verification
The histogram read of one calibration event can fall in the same cycle as the write-back of the event just before it. When both target the same bin, the fresh value must be forwarded, or else one increment is lost. The bench provokes this with a run of 200 back-to-back events on one bin, followed by a stride pattern that revisits bins. It then reads the finished tables back through measurements and compares them with cumulative values that it computes from its own count of accepted events. The second collision is a start and a stop rising in the same cycle. Here both lookups and the coarse close must happen together, and this is judged by a zero coarse count with both fine values correct.

// File: rtl/tdc_cal_pkg.sv
package tdc_cal_pkg;
  typedef enum logic [1:0] {
    ST_CAL   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_BUILD = 2'd2,
    ST_MEAS  = 2'd3
  } eng_state_e;
endpackage

// File: rtl/therm_decoder.sv
module therm_decoder #(
  parameter int THERM_W = 255,
  localparam int BIN_W  = $clog2(THERM_W + 1)
) (
  input  logic [THERM_W-1:0] therm_i,
  output logic [BIN_W-1:0]   bin_o
);
  // ones count, not first-zero search: bubble tolerant
  always_comb begin
    bin_o = '0;
    for (int i = 0; i < THERM_W; i++) bin_o = bin_o + BIN_W'(therm_i[i]);
  end
endmodule

// File: rtl/cal_line.sv
module cal_line #(
  parameter int NBINS  = 256,
  parameter int BIN_W  = 8,
  parameter int HIST_W = 15,
  parameter int LUT_W  = 21
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic [BIN_W-1:0] hit_bin_i,
  input  logic             build_i,
  input  logic [BIN_W-1:0] build_idx_i,
  input  logic [BIN_W-1:0] lk_bin_i,
  output logic [LUT_W-1:0] lk_val_o
);
  logic [HIST_W-1:0] hist_q [NBINS];
  logic [LUT_W-1:0]  lut_q  [NBINS];

  logic              s0_v, s1_v, lw_v;
  logic [BIN_W-1:0]  s0_bin, s1_bin, lw_bin;
  logic [HIST_W-1:0] s1_rd, lw_dat, base, nxt;
  logic [LUT_W-1:0]  acc_q, bld_dat;
  logic [HIST_W-1:0] bld_cnt;

  // the write of the previous event lands on the edge this read is taken
  always_comb begin
    base = (lw_v && lw_bin == s1_bin) ? lw_dat : s1_rd;
    nxt  = base + HIST_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_v   <= 1'b0;
      s0_bin <= '0;
      s1_v   <= 1'b0;
      s1_bin <= '0;
      s1_rd  <= '0;
      lw_v   <= 1'b0;
      lw_bin <= '0;
      lw_dat <= '0;
    end else begin
      s0_v   <= hit_i;
      s0_bin <= hit_bin_i;
      s1_v   <= s0_v;
      s1_bin <= s0_bin;
      s1_rd  <= hist_q[s0_bin];
      lw_v   <= s1_v;
      lw_bin <= s1_bin;
      lw_dat <= nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NBINS; i++) hist_q[i] <= '0;
    end else if (s1_v) begin
      hist_q[s1_bin] <= nxt;
    end
  end

  always_comb begin
    bld_cnt = hist_q[build_idx_i];
    bld_dat = acc_q + LUT_W'(bld_cnt >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else if (build_i) acc_q <= acc_q + LUT_W'(bld_cnt);
  end

  always_ff @(posedge clk_i) begin
    if (build_i) lut_q[build_idx_i] <= bld_dat;
  end

  assign lk_val_o = lut_q[lk_bin_i];

  assert_no_hist_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s1_v |-> nxt != '0);

  assert_lut_monotonic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (build_i && $past(build_i)) |-> bld_dat >= $past(bld_dat));
endmodule

// File: rtl/coarse_timer.sv
module coarse_timer #(
  parameter int COARSE_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                arm_i,
  input  logic                start_i,
  input  logic                stop_i,
  output logic                start_evt_o,
  output logic                stop_take_o,
  output logic                done_o,
  output logic [COARSE_W-1:0] coarse_o
);
  logic st1, st2, st3, sp1, sp2, sp3;
  logic run_q, done_q, stop_evt;
  logic [COARSE_W-1:0] cnt_q, coarse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) {st1, st2, st3, sp1, sp2, sp3} <= '0;
    else begin
      st1 <= start_i; st2 <= st1; st3 <= st2;
      sp1 <= stop_i;  sp2 <= sp1; sp3 <= sp2;
    end
  end

  assign start_evt_o = arm_i & st2 & ~st3;
  assign stop_evt    = arm_i & sp2 & ~sp3;
  assign stop_take_o = stop_evt & (run_q | start_evt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      coarse_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_evt_o && stop_evt) begin
        coarse_q <= '0;
        done_q   <= 1'b1;
        run_q    <= 1'b0;
      end else if (stop_evt && run_q) begin
        coarse_q <= cnt_q + COARSE_W'(1);
        done_q   <= 1'b1;
        run_q    <= 1'b0;
      end else if (start_evt_o) begin
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        cnt_q <= cnt_q + COARSE_W'(1);
      end
    end
  end

  assign done_o   = done_q;
  assign coarse_o = coarse_q;

  assert_start_sync_depth_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st2) |-> $past(start_i, 2));

  assert_no_result_unarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> arm_i);

  assert_orphan_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_evt && !run_q && !start_evt_o) |=> !done_q);
endmodule

// File: rtl/tdc_cal_engine.sv
module tdc_cal_engine #(
  parameter int THERM_W  = 255,
  parameter int CAL_LOG2 = 10,
  parameter int HIST_W   = 15,
  parameter int LUT_W    = 21,
  parameter int COARSE_W = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cal_hit_i,
  input  logic [THERM_W-1:0]  start_therm_i,
  input  logic [THERM_W-1:0]  stop_therm_i,
  input  logic                start_i,
  input  logic                stop_i,
  output logic                cal_done_o,
  output logic                result_valid_o,
  output logic [LUT_W-1:0]    fine1_o,
  output logic [LUT_W-1:0]    fine2_o,
  output logic [COARSE_W-1:0] coarse_o
);
  import tdc_cal_pkg::*;

  localparam int NBINS  = THERM_W + 1;
  localparam int BIN_W  = $clog2(NBINS);
  localparam int TOTAL  = 1 << CAL_LOG2;
  localparam int NLINES = 2;
  localparam int DRAIN_CYC = 3;

  eng_state_e         state_q;
  logic [CAL_LOG2:0]  hit_cnt_q;
  logic [1:0]         drain_q;
  logic [BIN_W-1:0]   bidx_q;
  logic               accept, build_en, start_evt, stop_take, done;
  logic [THERM_W-1:0] therm_w [NLINES];
  logic [BIN_W-1:0]   bin_w   [NLINES];
  logic [LUT_W-1:0]   lk_w    [NLINES];
  logic [LUT_W-1:0]   fine1_q, fine2_q;

  assign therm_w[0] = start_therm_i;
  assign therm_w[1] = stop_therm_i;
  assign accept     = (state_q == ST_CAL) && cal_hit_i;
  assign build_en   = (state_q == ST_BUILD);

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    therm_decoder #(.THERM_W(THERM_W)) u_dec (
      .therm_i (therm_w[g]),
      .bin_o   (bin_w[g])
    );
    cal_line #(.NBINS(NBINS), .BIN_W(BIN_W), .HIST_W(HIST_W), .LUT_W(LUT_W)) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .hit_i       (accept),
      .hit_bin_i   (bin_w[g]),
      .build_i     (build_en),
      .build_idx_i (bidx_q),
      .lk_bin_i    (bin_w[g]),
      .lk_val_o    (lk_w[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CAL;
      hit_cnt_q <= '0;
      drain_q   <= '0;
      bidx_q    <= '0;
    end else begin
      unique case (state_q)
        ST_CAL: if (accept) begin
          hit_cnt_q <= hit_cnt_q + 1'b1;
          if (hit_cnt_q == (CAL_LOG2+1)'(TOTAL - 1)) state_q <= ST_DRAIN;
        end
        ST_DRAIN: begin
          drain_q <= drain_q + 2'd1;
          if (drain_q == 2'(DRAIN_CYC)) state_q <= ST_BUILD;
        end
        ST_BUILD: begin
          bidx_q <= bidx_q + 1'b1;
          if (bidx_q == BIN_W'(NBINS - 1)) state_q <= ST_MEAS;
        end
        ST_MEAS: ;
        default: state_q <= ST_CAL;
      endcase
    end
  end

  assign cal_done_o = (state_q == ST_MEAS);

  coarse_timer #(.COARSE_W(COARSE_W)) u_coarse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (cal_done_o),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_evt_o (start_evt),
    .stop_take_o (stop_take),
    .done_o      (done),
    .coarse_o    (coarse_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine1_q <= '0;
      fine2_q <= '0;
    end else begin
      if (start_evt) fine1_q <= lk_w[0];
      if (stop_take) fine2_q <= lk_w[1];
    end
  end

  assign fine1_o        = fine1_q;
  assign fine2_o        = fine2_q;
  assign result_valid_o = done;

  assert_hit_count_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_q <= (CAL_LOG2+1)'(TOTAL));

  assert_done_after_build_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cal_done_o) |-> $past(state_q) == ST_BUILD && $past(bidx_q) == BIN_W'(NBINS - 1));

  assert_valid_needs_cal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> cal_done_o);
endmodule

// File: tb/tb_tdc_cal_engine.sv
module tb_tdc_cal_engine;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 255;
  localparam int NCAL = 1024;
  localparam int NSEND = 1044;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_hit_i = 1'b0;
  logic [TW-1:0] start_therm_i = '0;
  logic [TW-1:0] stop_therm_i = '0;
  logic start_i = 1'b0;
  logic stop_i = 1'b0;
  logic cal_done_o, result_valid_o;
  logic [20:0] fine1_o, fine2_o;
  logic [5:0] coarse_o;

  int n_chk = 0;
  int n_fail = 0;
  int h0 [256];
  int h1 [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_cal_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .cal_hit_i(cal_hit_i),
    .start_therm_i(start_therm_i), .stop_therm_i(stop_therm_i),
    .start_i(start_i), .stop_i(stop_i), .cal_done_o(cal_done_o),
    .result_valid_o(result_valid_o), .fine1_o(fine1_o), .fine2_o(fine2_o),
    .coarse_o(coarse_o)
  );

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] mk_code(int bin, bit bubble);
    logic [TW-1:0] c = '0;
    if (!bubble || bin < 2) begin
      for (int i = 0; i < bin; i++) c[i] = 1'b1;
    end else begin
      for (int i = 0; i <= bin; i++) c[i] = 1'b1;
      c[bin/2] = 1'b0;
    end
    return c;
  endfunction

  function automatic int exp_lut(int line, int bin);
    int s = 0;
    for (int j = 0; j < bin; j++) s += (line == 0) ? h0[j] : h1[j];
    s += ((line == 0) ? h0[bin] : h1[bin]) / 2;
    return s;
  endfunction

  function automatic int bin0_of(int k);
    if (k < 200) return 37;
    if (k >= NCAL) return 255;
    return (k * 13) % 256;
  endfunction

  function automatic int bin1_of(int k);
    if (k >= NCAL) return 2;
    return (k % 5) * 50 + 3;
  endfunction

  // one measurement; returns through outputs; dly = stop delay in cycles
  task automatic measure(int dly, int b0, int b1, bit bub, output bit got,
                         output int f1, output int f2, output int crs);
    got = 0; f1 = 0; f2 = 0; crs = 0;
    @(negedge clk);
    start_therm_i = mk_code(b0, 1'b0);
    stop_therm_i  = mk_code(b1, bub);
    start_i = 1'b1;
    if (dly == 0) stop_i = 1'b1;
    for (int i = 0; i < dly + 8; i++) begin
      @(negedge clk);
      if (i == dly - 1) stop_i = 1'b1;
      if (result_valid_o && !got) begin
        got = 1; f1 = fine1_o; f2 = fine2_o; crs = coarse_o;
      end
    end
    start_i = 1'b0; stop_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 cal_done after reset", cal_done_o, 0);
    check("R1 valid after reset", result_valid_o, 0);
  endtask

  task automatic t_unarmed;
    bit seen = 0;
    @(negedge clk); start_i = 1'b1;
    repeat (3) @(negedge clk); stop_i = 1'b1;
    repeat (8) begin @(negedge clk); if (result_valid_o) seen = 1; end
    start_i = 1'b0; stop_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 no result before calibration", seen, 0);
  endtask

  task automatic t_calibrate;
    int wait_cyc = 0;
    for (int b = 0; b < 256; b++) begin h0[b] = 0; h1[b] = 0; end
    for (int k = 0; k < NSEND; k++) begin
      @(negedge clk);
      cal_hit_i = 1'b1;
      start_therm_i = mk_code(bin0_of(k), 1'b0);
      stop_therm_i  = mk_code(bin1_of(k), k[0]);
      if (k < NCAL) begin h0[bin0_of(k)]++; h1[bin1_of(k)]++; end
    end
    @(negedge clk);
    cal_hit_i = 1'b0;
    check("R5 cal_done not early", cal_done_o, 0);
    while (!cal_done_o && wait_cyc < 1000) begin @(negedge clk); wait_cyc++; end
    check("R5 cal_done rises", cal_done_o, 1);
    check("R5 build takes all bins", (wait_cyc >= 236) ? 1 : 0, 1);
  endtask

  task automatic t_lookup(string req, int dly, int b0, int b1, bit bub, int exp_crs);
    bit got; int f1, f2, crs;
    measure(dly, b0, b1, bub, got, f1, f2, crs);
    check({req, " valid"}, got, 1);
    check({req, " fine1"}, f1, exp_lut(0, b0));
    check({req, " fine2"}, f2, exp_lut(1, b1));
    check({req, " coarse"}, crs, exp_crs);
  endtask

  task automatic t_orphan_stop;
    bit seen = 0;
    @(negedge clk); stop_i = 1'b1;
    repeat (8) begin @(negedge clk); if (result_valid_o) seen = 1; end
    stop_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 orphan stop ignored", seen, 0);
  endtask

  task automatic t_restart;
    bit got = 0; int crs = 0;
    @(negedge clk); start_i = 1'b1; start_therm_i = mk_code(100, 1'b0);
    repeat (5) @(negedge clk); start_i = 1'b0;
    repeat (3) @(negedge clk); start_i = 1'b1;
    repeat (4) @(negedge clk); stop_i = 1'b1; stop_therm_i = mk_code(153, 1'b0);
    repeat (8) begin
      @(negedge clk);
      if (result_valid_o && !got) begin got = 1; crs = coarse_o; end
    end
    start_i = 1'b0; stop_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 restart valid", got, 1);
    check("R10 restart coarse", crs, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_unarmed();
    t_calibrate();
    // R3 forwarded burst bin; R4 extra hits landed on 255/2 and must be absent
    t_lookup("R3 burst bin", 5, 37, 53, 1'b0, 5);
    t_lookup("R4 top bin", 3, 255, 2, 1'b0, 3);
    t_lookup("R5 bin zero", 7, 0, 3, 1'b0, 7);
    t_lookup("R2 bubble code", 6, 100, 53, 1'b1, 6);
    t_lookup("R7 mid bins", 2, 200, 203, 1'b0, 2);
    t_lookup("R8 simultaneous", 0, 13, 153, 1'b0, 0);
    t_lookup("R8 wrap", 70, 26, 103, 1'b0, 6);
    t_lookup("R6 one cycle", 1, 39, 0, 1'b0, 1);
    t_orphan_stop();
    t_restart();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule